// File: doc/BRIEF.md
# ADC Serial Result Framer

This block drives the serial output pins of a 14-bit analog-to-digital converter. A one-cycle conversion-start pulse latches the result word and opens a frame at once. The frame lasts 16 bit times: two zero bits, then the result with the most significant bit first. The serial clock is the master clock divided by two. The frame is marked by an active-low strobe. Data changes when the serial clock rises and is sampled by the receiver when the serial clock falls.

Each pin is modelled as a level plus an output enable, so that a pad wrapper can build open-drain or tristate behaviour from it. A mode input picks the serial clock behaviour. In gated mode the clock is driven only while a frame is in progress and is released afterwards, so several converters can share one bus. In continuous mode the clock toggles all the time, and its phase is realigned at each conversion start.

Top module: `adc_sframer`

## Requirements
- R1: During and after reset, with no start seen, strobeOut is 1, sdataOe is 0 and sclkOut is 0. strobeOe is always 1.
- R2: A convStart sampled high on a rising master-clock edge while idle drives strobeOut to 0 from that edge. strobeOut then stays 0 for exactly 32 master-clock cycles and returns to 1 on the 32nd edge after the start edge.
- R3: The frame carries 16 bits. Frame bit i (i = 0..15) is 0 for i < 2 and result[15-i] otherwise, so the result goes out most significant bit first.
- R4: Counting the start edge as edge 0, sclkOut is 1 after even edges and 0 after odd edges up to edge 31. Frame bit k is presented on sdataOut from edge 2k to edge 2k+1, so it is stable across the falling serial edge at edge 2k+1. The first bit is therefore sampled one master cycle after the strobe falls.
- R5: With clkFree = 0, sclkOe is 1 only while strobeOut is 0, and sclkOut is 0 while released.
- R6: With clkFree = 1, sclkOe is always 1. While idle and with no start, sclkOut inverts on every master-clock edge, and this includes the edge that ends a frame.
- R7: The result is captured at the start edge. A change on result during a frame does not alter the bits sent.
- R8: A convStart that arrives while a frame is in progress is ignored. The frame runs to its normal end with unchanged content and timing.
- R9: sdataOe is 1 exactly while strobeOut is 0, so the data line is released on the same edge that raises the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convStart | input | 1 | One-cycle conversion-start pulse |
| result | input | 14 | Conversion result to be sent |
| clkFree | input | 1 | 1: serial clock runs continuously; 0: clock driven only during a frame |
| sclkOut | output | 1 | Serial clock level |
| sclkOe | output | 1 | Serial clock drive enable |
| sdataOut | output | 1 | Serial data level |
| sdataOe | output | 1 | Serial data drive enable |
| strobeOut | output | 1 | Active-low frame strobe level |
| strobeOe | output | 1 | Frame strobe drive enable |

## Verification
Every frame is checked on every master-clock cycle against a model computed from the result word. Frames are sent with walking ones, walking zeros, all-zero, all-one, two alternating patterns and a few hundred arithmetic pseudo-random words. This exposes bit-order, shift-alignment and stuck-bit faults. Each pattern runs in both clock modes, which separates gated release from continuous toggling and phase realignment. Some frames change the result input in mid-frame, or pulse start again in mid-frame, to show that the captured word and the frame timing cannot be disturbed.

// File: rtl/adc_sframer_pkg.sv
package adc_sframer_pkg;

  // Strobes passed from the frame sequencer to the shift datapath.
  typedef struct packed {
    logic load;    // capture the result word at the start edge
    logic shift;   // advance to the next frame bit on a serial rising edge
    logic active;  // frame in progress
  } frameCtl_t;

endpackage

// File: rtl/adc_sframer_ctrl.sv
module adc_sframer_ctrl
  import adc_sframer_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      convStart,
  input  logic      clkFree,
  output logic      sclkQ,
  output frameCtl_t ctl
);

  localparam int EDGES = 2 * FRAME_W;
  localparam int CNT_W = $clog2(EDGES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(EDGES - 1);

  logic             activeQ;
  logic [CNT_W-1:0] edgeCnt;
  logic             startAcc;
  logic             lastEdge;

  assign startAcc = convStart && !activeQ;
  assign lastEdge = activeQ && (edgeCnt == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      edgeCnt <= '0;
      sclkQ   <= 1'b0;
    end else if (startAcc) begin
      activeQ <= 1'b1;
      edgeCnt <= '0;
      sclkQ   <= 1'b1;
    end else if (lastEdge) begin
      activeQ <= 1'b0;
      edgeCnt <= '0;
      sclkQ   <= clkFree ? ~sclkQ : 1'b0;
    end else if (activeQ) begin
      edgeCnt <= edgeCnt + 1'b1;
      sclkQ   <= ~sclkQ;
    end else begin
      sclkQ   <= clkFree ? ~sclkQ : 1'b0;
    end
  end

  always_comb begin
    ctl.load   = startAcc;
    ctl.shift  = activeQ && edgeCnt[0] && !lastEdge;
    ctl.active = activeQ;
  end

endmodule

// File: rtl/adc_sframer_dp.sv
module adc_sframer_dp
  import adc_sframer_pkg::*;
#(
  parameter int RES_W  = 14,
  parameter int LEAD_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  frameCtl_t        ctl,
  input  logic [RES_W-1:0] result,
  output logic             bitOut
);

  localparam int FRAME_W = RES_W + LEAD_W;

  logic [FRAME_W-1:0] shiftQ;
  logic [FRAME_W-1:0] loadVal;

  generate
    if (LEAD_W > 0) begin : g_lead
      assign loadVal = {{LEAD_W{1'b0}}, result};
    end else begin : g_nolead
      assign loadVal = result;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (ctl.load) begin
      shiftQ <= loadVal;
    end else if (ctl.shift) begin
      shiftQ <= {shiftQ[FRAME_W-2:0], 1'b0};
    end
  end

  assign bitOut = shiftQ[FRAME_W-1];

endmodule

// File: rtl/adc_sframer.sv
module adc_sframer
  import adc_sframer_pkg::*;
#(
  parameter int RES_W  = 14,
  parameter int LEAD_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStart,
  input  logic [RES_W-1:0] result,
  input  logic             clkFree,
  output logic             sclkOut,
  output logic             sclkOe,
  output logic             sdataOut,
  output logic             sdataOe,
  output logic             strobeOut,
  output logic             strobeOe
);

  localparam int FRAME_W = RES_W + LEAD_W;

  frameCtl_t ctl;
  logic      sclkQ;
  logic      bitOut;

  adc_sframer_ctrl #(
    .FRAME_W(FRAME_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .convStart(convStart),
    .clkFree  (clkFree),
    .sclkQ    (sclkQ),
    .ctl      (ctl)
  );

  adc_sframer_dp #(
    .RES_W (RES_W),
    .LEAD_W(LEAD_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .result(result),
    .bitOut(bitOut)
  );

  assign sclkOut   = sclkQ;
  assign sclkOe    = ctl.active | clkFree;
  assign sdataOut  = bitOut;
  assign sdataOe   = ctl.active;
  assign strobeOut = ~ctl.active;
  assign strobeOe  = 1'b1;

endmodule

// File: rtl/adc_sframer_chk.sv
module adc_sframer_chk (
  input logic clk,
  input logic rstN,
  input logic convStart,
  input logic clkFree,
  input logic sclkOut,
  input logic sclkOe,
  input logic sdataOut,
  input logic sdataOe,
  input logic strobeOut
);

  a_r9_data_oe_tracks_strobe: assert property (@(posedge clk) disable iff (!rstN)
    sdataOe == !strobeOut);

  a_r2_start_drops_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOut && convStart) |=> !strobeOut);

  a_r3_first_bit_zero: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeOut) |-> (!sdataOut && sclkOut));

  a_r4_stable_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeOut && $past(!strobeOut) && $fell(sclkOut)) |-> $stable(sdataOut));

  a_r5_gated_release: assert property (@(posedge clk) disable iff (!rstN)
    (!clkFree && strobeOut) |-> (!sclkOe && !sclkOut));

  a_r6_free_toggles: assert property (@(posedge clk) disable iff (!rstN)
    (clkFree && strobeOut && !convStart) |=> (sclkOe && (sclkOut != $past(sclkOut))));

endmodule

bind adc_sframer adc_sframer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .convStart(convStart),
  .clkFree  (clkFree),
  .sclkOut  (sclkOut),
  .sclkOe   (sclkOe),
  .sdataOut (sdataOut),
  .sdataOe  (sdataOe),
  .strobeOut(strobeOut)
);

// File: tb/adc_sframer_tb.sv
`timescale 1ns/1ps
module adc_sframer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convStart = 1'b0;
  logic [13:0] result = '0;
  logic        clkFree = 1'b0;
  logic        sclkOut, sclkOe, sdataOut, sdataOe, strobeOut, strobeOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_sframer u_dut (
    .clk(clk), .rstN(rstN), .convStart(convStart), .result(result),
    .clkFree(clkFree), .sclkOut(sclkOut), .sclkOe(sclkOe),
    .sdataOut(sdataOut), .sdataOe(sdataOe), .strobeOut(strobeOut),
    .strobeOe(strobeOe)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic int frameBit(input logic [13:0] v, input int i);
    return (i < 2) ? 0 : int'(v[15 - i]);
  endfunction

  // One frame; midChange alters result mid-frame (R7), midStart pulses start mid-frame (R8).
  task automatic runFrame(input logic [13:0] v, input bit free, input bit midChange,
                          input bit midStart);
    logic prevSclk;
    clkFree = free;
    @(negedge clk);
    result = v;
    convStart = 1'b1;
    @(posedge clk);
    for (int j = 0; j <= 32; j++) begin
      @(negedge clk);
      convStart = 1'b0;
      if (j < 32) begin
        chk("R2 strobe low in frame", int'(strobeOut), 0);
        chk("R9 data driven in frame", int'(sdataOe), 1);
        chk("R4 sclk phase", int'(sclkOut), (j % 2 == 0) ? 1 : 0);
        chk("R3 R7 R8 frame bit", int'(sdataOut), frameBit(v, j / 2));
        chk("R5 R6 sclk driven in frame", int'(sclkOe), 1);
      end else begin
        chk("R2 strobe high after 32 cycles", int'(strobeOut), 1);
        chk("R9 data released", int'(sdataOe), 0);
        chk("R5 R6 sclk oe after frame", int'(sclkOe), free ? 1 : 0);
        chk("R5 R6 sclk after frame", int'(sclkOut), free ? 1 : 0);
      end
      if (midChange && j == 5) result = ~v;
      if (midStart && j == 10) convStart = 1'b1;
    end
    prevSclk = sclkOut;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (free) begin
        chk("R6 idle toggle", int'(sclkOut), int'(!prevSclk));
        chk("R6 idle oe", int'(sclkOe), 1);
      end else begin
        chk("R5 idle low", int'(sclkOut), 0);
        chk("R5 idle released", int'(sclkOe), 0);
      end
      chk("R1 idle strobe", int'(strobeOut), 1);
      prevSclk = sclkOut;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", int'(strobeOut), 1);
    chk("R1 reset data oe", int'(sdataOe), 0);
    chk("R1 reset sclk", int'(sclkOut), 0);
    chk("R1 strobe oe", int'(strobeOe), 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset strobe", int'(strobeOut), 1);
    chk("R1 idle after reset data oe", int'(sdataOe), 0);
    chk("R1 idle after reset sclk", int'(sclkOut), 0);
    for (int m = 0; m < 2; m++) begin
      runFrame(14'h0000, m[0], 1'b0, 1'b0);
      runFrame(14'h3FFF, m[0], 1'b0, 1'b0);
      runFrame(14'h2AAA, m[0], 1'b1, 1'b0);
      runFrame(14'h1555, m[0], 1'b0, 1'b1);
      for (int b = 0; b < 14; b++) begin
        runFrame(14'(1 << b), m[0], 1'b0, 1'b0);
        runFrame(~14'(1 << b), m[0], 1'b0, 1'b0);
      end
      for (int r = 0; r < 200; r++) begin
        runFrame(14'((r * 7919 + 123 + m * 4001) & 16'h3FFF), m[0], r[0], r[1] & r[2]);
      end
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule